// File: doc/BRIEF.md
# Serial EEPROM Slave Emulator

This block answers an SPI master as a small byte-wide serial EEPROM would. It holds a 256 x 8 array in internal registers and runs in the system clock domain. The chip select, serial clock and data-in pins are synchronised, and their edges are found by comparing registered samples. Each transfer starts when chip select falls. The first byte is an instruction. Depending on the instruction, an address byte, data bytes, or status bytes follow it. All bytes travel most-significant bit first, in SPI mode 0.

Array and status writes are held back until chip select rises. A write is committed only if the master sent a whole number of bytes and the write enable latch was set when the instruction arrived. A commit starts an internal write cycle that lasts a set number of system clocks. During that cycle the status register reads all ones, and the only instruction obeyed is the status read. Two block-protect bits choose how much of the top of the array refuses writes. The write-protect input acts only on the instruction that sets the latch.

Top module: `spi_eeprom_emu`

## Requirements
- R1: An instruction byte is decoded only if its bits 7:4 are zero. Bit 3 is ignored. Bits 2:0 select the instruction: 110 set latch, 100 clear latch, 101 status read, 001 status write, 011 array read, 010 array write. Any other byte makes the rest of the transfer ignored.
- R2: After reset the write enable latch is clear, both protect bits are zero and the device is ready, so a status read returns 8'h00.
- R3: The set-latch instruction sets the write enable latch only while `wp_n` is high. The clear-latch instruction clears it at any `wp_n` level.
- R4: When ready, the status byte is {4'b0000, bp1, bp0, wel, 1'b0}: bit 0 is busy, bit 1 is the latch, and bits 3:2 are the protect bits. During a write cycle it reads 8'hFF. A status read repeats the status byte for as long as chip select stays low.
- R5: An array read takes one address byte. It then returns the byte at that address and at each following address, wrapping from 255 to 0.
- R6: An array write takes one address byte and then data bytes. Each data byte goes to the next location within the aligned 8-byte page, and the address wraps inside the page. The bytes are committed when chip select rises, only if no partial byte was sent and the latch was set when the instruction was decoded.
- R7: A committed array or status write makes the device busy for BUSY_CYCLES clocks and clears the latch. While busy, every instruction except the status read is ignored, including the set-latch instruction.
- R8: A status write with the latch set copies bits 3:2 of its data byte into the protect bits when chip select rises, provided a whole byte was received.
- R9: The protect bits choose the locked addresses: 00 none, 01 addresses 192 to 255, 10 addresses 128 to 255, 11 all addresses. A write to a locked address leaves that location unchanged.
- R10: `miso_en` is high only while chip select is active. `miso` changes after falling serial clock edges and is valid for the master to sample before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from master |
| mosi | input | 1 | Serial data from master |
| wp_n | input | 1 | Write protect, low blocks latch setting |
| miso | output | 1 | Serial data to master, high-impedance when deselected |
| miso_en | output | 1 | High while miso is driven |

## Verification
Every cycle, the checker confirms the following:
- the output stays disabled while chip select is idle;
- the latch can only rise with `wp_n` high;
- the latch is clear whenever a write cycle begins, and that cycle lasts more than one clock;
- the protect bits change only when a write cycle starts.

Only the bench scenarios can show the data-path behaviour:
- read-address wrap and in-page write wrap;
- partial-byte aborts;
- protected writes being dropped;
- instructions ignored while busy;
- the all-ones status.

The bench compares these against an array model that it keeps itself.

// File: rtl/spi_eeprom_emu.sv
module spi_eeprom_emu #(
  parameter int BUSY_CYCLES = 64,
  parameter int PAGE_BYTES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic miso_en
);
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {P_CMD, P_ADDR, P_RD, P_WR, P_SR, P_WS, P_IGN} phase_t;

  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [2:0] csn_s, sck_s;
  logic [1:0] mosi_s;
  phase_t phase;
  logic [2:0] bitcnt;
  logic [7:0] shin, out_sr, addr;
  logic rd, wel, busy, sr_got;
  logic [1:0] bp, sr_new;
  logic [CW-1:0] cnt;

  wire active   = !csn_s[1];
  wire csn_fall = !csn_s[1] && csn_s[2];
  wire csn_rise = csn_s[1] && !csn_s[2];
  wire sck_rise = sck_s[1] && !sck_s[2];
  wire sck_fall = !sck_s[1] && sck_s[2];
  wire [7:0] rx_byte = {shin[6:0], mosi_s[1]};
  wire [7:0] status  = busy ? 8'hFF : {4'b0000, bp, wel, 1'b0};
  wire [7:0] nxt     = (phase == P_SR) ? status : (phase == P_RD) ? mem[addr] : 8'h00;

  function automatic logic locked(input logic [1:0] b, input logic [AW-1:0] a);
    case (b)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (a[AW-1:AW-2] == 2'b11);
      2'b10:   locked = a[AW-1];
      default: locked = 1'b1;
    endcase
  endfunction

  assign miso_en = active;
  assign miso    = miso_en ? out_sr[7] : 1'bz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csn_s <= '1; sck_s <= '0; mosi_s <= '0;
      phase <= P_IGN; bitcnt <= '0; shin <= '0; out_sr <= '0; addr <= '0;
      rd <= 1'b0; wel <= 1'b0; busy <= 1'b0; sr_got <= 1'b0;
      bp <= '0; sr_new <= '0; cnt <= '0; mask <= '0;
    end else begin
      csn_s  <= {csn_s[1:0], cs_n};
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
      if (csn_fall) begin
        phase <= P_CMD; bitcnt <= '0; mask <= '0; sr_got <= 1'b0; out_sr <= '0;
      end else if (active && sck_rise) begin
        shin   <= rx_byte;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == 3'd7) begin
          case (phase)
            P_CMD: begin
              phase <= P_IGN;
              if (rx_byte[7:4] == 4'b0000 && (!busy || rx_byte[2:0] == 3'b101)) begin
                case (rx_byte[2:0])
                  3'b110: if (wp_n) wel <= 1'b1;
                  3'b100: wel <= 1'b0;
                  3'b101: phase <= P_SR;
                  3'b001: if (wel) phase <= P_WS;
                  3'b011: begin phase <= P_ADDR; rd <= 1'b1; end
                  3'b010: if (wel) begin phase <= P_ADDR; rd <= 1'b0; end
                  default: ;
                endcase
              end
            end
            P_ADDR: begin addr <= rx_byte; phase <= rd ? P_RD : P_WR; end
            P_RD:   addr <= addr + 1'b1;
            P_WR: begin
              pbuf[addr[PW-1:0]] <= rx_byte;
              mask[addr[PW-1:0]] <= 1'b1;
              addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
            end
            P_WS: begin sr_new <= rx_byte[3:2]; sr_got <= 1'b1; end
            default: ;
          endcase
        end
      end else if (active && sck_fall) begin
        out_sr <= (bitcnt == 3'd0) ? nxt : {out_sr[6:0], 1'b0};
      end else if (csn_rise) begin
        phase <= P_IGN;
        if (bitcnt == 3'd0 && ((phase == P_WR && mask != '0) || (phase == P_WS && sr_got))) begin
          busy <= 1'b1;
          cnt  <= CW'(BUSY_CYCLES - 1);
          wel  <= 1'b0;
          if (phase == P_WS) bp <= sr_new;
          else
            for (int i = 0; i < PAGE_BYTES; i++)
              if (mask[i] && !locked(bp, {addr[AW-1:PW], PW'(i)}))
                mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
        end
      end
    end
  end
endmodule

module spi_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wp_n,
  input logic miso_en,
  input logic busy,
  input logic wel,
  input logic [1:0] bp
);
  AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso_en); // R10
  AST_WEL_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> wp_n); // R3
  AST_WEL_CLR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R7
  AST_BP_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $rose(busy)); // R8
endmodule

bind spi_eeprom_emu spi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .miso_en(miso_en),
  .busy(busy), .wel(wel), .bp(bp)
);

// File: tb/sim_spi_eeprom_emu.sv
`timescale 1ns/1ps
module sim_spi_eeprom_emu;
  localparam int H = 6;
  localparam int BUSY = 400;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, mosi = 0, wp_n = 1;
  wire miso, miso_en;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] exp_mem [256];

  spi_eeprom_emu #(.BUSY_CYCLES(BUSY), .PAGE_BYTES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .miso_en(miso_en));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    cs_n = 0; wt(H);
  endtask

  task automatic cs_hi();
    wt(H); cs_n = 1; wt(2 * H);
  endtask

  task automatic bits(input logic [7:0] d, input int n, output logic [7:0] r);
    r = 0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i]; wt(H);
      r = {r[6:0], miso};
      sck = 1; wt(H); sck = 0;
    end
  endtask

  task automatic xb(input logic [7:0] d, output logic [7:0] r);
    bits(d, 8, r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xb(op, r); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); xb(8'h05, r); xb(8'h00, s); cs_hi();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) return;
    end
    chk("R7 ready timeout", 8'h01, 8'h00);
  endtask

  task automatic wr_page(input logic [7:0] a, input int n, input logic [7:0] base);
    logic [7:0] r;
    cs_lo(); xb(8'h02, r); xb(a, r);
    for (int i = 0; i < n; i++) xb(base + 8'(i), r);
    cs_hi();
  endtask

  task automatic model_wr(input logic [7:0] a, input int n, input logic [7:0] base, input logic [1:0] b);
    for (int i = 0; i < n; i++) begin
      logic [7:0] x;
      x = {a[7:3], 3'(a[2:0] + 3'(i))};
      if (!(b == 2'b11 || (b == 2'b10 && x[7]) || (b == 2'b01 && x[7:6] == 2'b11)))
        exp_mem[x] = base + 8'(i);
    end
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input int n);
    logic [7:0] r;
    cs_lo(); xb(8'h03, r); xb(a, r);
    for (int i = 0; i < n; i++) begin
      xb(8'h00, r);
      chk(tag, r, exp_mem[8'(a + 8'(i))]);
    end
    cs_hi();
  endtask

  task automatic set_bp(input logic [1:0] b);
    logic [7:0] r;
    cmd1(8'h06);
    cs_lo(); xb(8'h01, r); xb({4'h0, b, 2'b00}, r); cs_hi();
    wait_ready();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r;
    wt(5); rst_n = 1; wt(5);
    chk("R10 idle miso_en", {7'b0, miso_en}, 8'h00);
    rdsr(s); chk("R2 reset status", s, 8'h00);

    wp_n = 0; cmd1(8'h06); rdsr(s); chk("R3 set latch blocked by wp_n low", s, 8'h00);
    wp_n = 1; cmd1(8'h0E); rdsr(s); chk("R1 bit3 ignored, latch set", s, 8'h02);
    wp_n = 0; cmd1(8'h04); rdsr(s); chk("R3 clear latch with wp_n low", s, 8'h00);
    wp_n = 1; cmd1(8'h16); rdsr(s); chk("R1 nonzero upper bits ignored", s, 8'h00);

    cs_lo(); xb(8'h05, r); chk("R10 miso_en while selected", {7'b0, miso_en}, 8'h01);
    xb(8'h00, s); xb(8'h00, r); cs_hi();
    chk("R4 status repeats", r, s);

    for (int p = 0; p < 32; p++) begin
      cmd1(8'h06);
      wr_page(8'(p * 8), 8, 8'(p * 8 * 7 + 3) ^ 8'h5A);
      for (int i = 0; i < 8; i++) exp_mem[p * 8 + i] = 8'((p * 8 * 7 + 3) ^ 8'h5A) + 8'(i);
      if (p == 0) begin
        rdsr(s); chk("R4 all ones while busy", s, 8'hFF);
        cmd1(8'h06);
      end
      wait_ready();
      if (p == 0) begin
        rdsr(s); chk("R7 latch cleared, set-latch ignored while busy", s, 8'h00);
      end
    end
    cs_lo(); xb(8'h0B, r); xb(8'h00, r);
    for (int a = 0; a < 258; a++) begin
      xb(8'h00, r); chk("R5 full sweep read with wrap", r, exp_mem[8'(a)]);
    end
    cs_hi();

    rd_check("R5 wrap 255 to 0", 8'hFE, 4);

    cmd1(8'h06); wr_page(8'h15, 5, 8'hC0); model_wr(8'h15, 5, 8'hC0, 2'b00); wait_ready();
    rd_check("R6 in-page wrap", 8'h10, 8);

    cmd1(8'h06);
    cs_lo(); xb(8'h02, r); xb(8'h40, r); xb(8'hAA, r); bits(8'hFF, 3, r); cs_hi();
    rdsr(s); chk("R6 partial byte not committed", s, 8'h02);
    rd_check("R6 partial byte data unchanged", 8'h40, 1);
    cmd1(8'h04);
    wr_page(8'h48, 1, 8'h11); rdsr(s); chk("R6 write without latch ignored", s, 8'h00);
    rd_check("R6 write without latch data", 8'h48, 1);

    for (int b = 1; b < 4; b++) begin
      set_bp(2'(b));
      rdsr(s); chk("R8 protect bits in status", s, {4'h0, 2'(b), 2'b00});
      for (int q = 0; q < 4; q++) begin
        cmd1(8'h06);
        wr_page(8'(q * 64 + 5), 1, ~exp_mem[q * 64 + 5]);
        model_wr(8'(q * 64 + 5), 1, ~exp_mem[q * 64 + 5], 2'(b));
        wait_ready();
        rd_check("R9 protected range", 8'(q * 64 + 5), 1);
      end
    end
    set_bp(2'b00); rdsr(s); chk("R8 protect bits cleared", s, 8'h00);
    cmd1(8'h06);
    cs_lo(); xb(8'h01, r); bits(8'h0C, 5, r); cs_hi();
    rdsr(s); chk("R8 partial status write ignored", s, 8'h02);
    cmd1(8'h04);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule